// File: doc/BRIEF.md
# MII Management Register Front-End

This block sits between a host register bus and a single modelled Ethernet PHY. Software uses it to read and write PHY management registers. It does not drive a serial management line. Software first loads a target address word that holds a PHY address and a PHY register index. A write into the data word then starts a PHY write cycle. Raising the read-request bit of the command word starts a PHY read cycle, and the 16-bit result appears in the result word.

The modelled PHY keeps a writable control register and a status register. The status register's link bit follows an external link input. The PHY model also returns a fixed 1000BASE-T status word. Every completed management cycle sets a busy flag for one clock and raises a sticky completion flag. Software clears the completion flag by writing a one to it. A few general registers of each access type (read-write, write-only, write-one-to-clear, read-only) share the same host bus.

The host write and read ports are separate. A write takes effect at the clock edge where `host_we` is high. Read data is a combinational function of `host_raddr`.

Top module: `mii_mgmt_front`

## Requirements
- R1: After reset, words 0 to 6 read as 0, the identity word 7 reads `ID_VALUE`, `mgmt_busy` and `op_done` are 0, the PHY control register holds 0x1140, and the PHY status register holds 0x7809 with bit 2 taken from `link_up`.
- R2: The command word (index 0) stores every written value in full. A read cycle starts only when a host write changes command bit 0 from 0 to 1. Writing 1 while bit 0 is already 1 starts no cycle.
- R3: A read cycle loads the result word (index 3) with a value chosen by PHY register index bits 4:0 of the address word (index 1): index 0 gives the control register, index 1 gives the status register, index 10 gives 0x1800, and every other index gives 0.
- R4: The PHY address field (bits 12:8 of the address word) selects nothing. Every PHY address reaches the same modelled PHY.
- R5: Every host write to the data word (index 2) keeps only the low 16 bits, which read back zero-extended, and performs a PHY write cycle at once.
- R6: A write cycle to PHY register 0 stores the data with bits 15 and 8 cleared. Write cycles to any other PHY register index change nothing.
- R7: PHY status bit 2 is 1 while `link_up` is high and 0 while it is low. It follows the input one clock later.
- R8: `mgmt_busy` (also bit 0 of word 4) is high for exactly the one clock after the edge that starts a read or write cycle, and at that point the result word is already valid. It is never high without such a start.
- R9: Bit 1 of word 4 (`op_done`) is set on the clock after busy and stays set. A host write with bit 1 high clears it, and a write with bit 1 low leaves it set. Setting wins over clearing.
- R10: Word 5 is read-write. Word 6 is write-only and reads 0. Word 7 is read-only. Words 8 to 15 read 0 and ignore writes.
- R11: When a command write that starts a read and a change of `link_up` happen in the same cycle, the result holds the status value from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_waddr | input | ADDR_W | Host write word index |
| host_wdata | input | DATA_W | Host write data |
| host_raddr | input | ADDR_W | Host read word index |
| host_rdata | output | DATA_W | Host read data (combinational) |
| link_up | input | 1 | External link indication |
| mgmt_busy | output | 1 | Management cycle completing |
| op_done | output | 1 | Sticky completion flag |

## Verification
The bench builds the block with `ADDR_W` = 4 and `DATA_W` = 32. This covers the whole 16-word host map, including the unmapped words 8 to 15. It overrides `ID_VALUE` with a nonzero pattern, so the read-only word can be told apart from unmapped words and from write-only reads. With a 32-bit data path, writes with upper bits set can show the 16-bit truncation of the data word and the full storage of the command word.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;

    localparam int PHY_DW = 16;
    localparam int IDX_W  = 5;

    // host word indices
    localparam int W_CMD     = 0;
    localparam int W_TARGET  = 1;
    localparam int W_DATA    = 2;
    localparam int W_RESULT  = 3;
    localparam int W_IND     = 4;
    localparam int W_SCRATCH = 5;
    localparam int W_KEY     = 6;
    localparam int W_IDENT   = 7;

    localparam int IND_BUSY_BIT = 0;
    localparam int IND_DONE_BIT = 1;
    localparam int CMD_RD_BIT   = 0;

    // modelled PHY
    localparam logic [IDX_W-1:0]  PREG_CTRL = 5'd0;
    localparam logic [IDX_W-1:0]  PREG_STAT = 5'd1;
    localparam logic [IDX_W-1:0]  PREG_T2   = 5'd10;
    localparam logic [PHY_DW-1:0] CTRL_INIT  = 16'h1140;
    localparam logic [PHY_DW-1:0] STAT_INIT  = 16'h7809;
    localparam logic [PHY_DW-1:0] CTRL_STRIP = 16'h8100;
    localparam logic [PHY_DW-1:0] T2_FIXED   = 16'h1800;
    localparam int LINK_BIT = 2;

    typedef enum logic [1:0] {
        ACC_RW,
        ACC_WO,
        ACC_W1C,
        ACC_RO
    } acc_kind_e;

    typedef struct packed {
        logic             rd_go;
        logic             wr_go;
        logic [IDX_W-1:0] reg_idx;
        logic [IDX_W-1:0] phy_addr;
    } mgmt_req_t;

    function automatic logic [PHY_DW-1:0] merge_link(input logic [PHY_DW-1:0] base,
                                                     input logic up);
        logic [PHY_DW-1:0] v;
        v = base;
        v[LINK_BIT] = up;
        return v;
    endfunction

    function automatic logic [PHY_DW-1:0] strip_ctrl(input logic [PHY_DW-1:0] d);
        return d & ~CTRL_STRIP;
    endfunction

endpackage

// File: rtl/acc_reg.sv
module acc_reg
    import mii_mgmt_pkg::*;
#(
    parameter int          W     = 32,
    parameter acc_kind_e   KIND  = ACC_RW,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] set_i,
    output logic [W-1:0] q,
    output logic [W-1:0] rdata
);

    generate
        if (KIND == ACC_RO) begin : g_ro
            logic unused_ro;
            assign unused_ro = ^{clk, rst, we, wdata, set_i};
            assign q     = INIT;
            assign rdata = INIT;
        end else if (KIND == ACC_W1C) begin : g_w1c
            logic [W-1:0] st_q;
            always_ff @(posedge clk) begin
                if (rst) st_q <= INIT;
                else     st_q <= (st_q & ~(we ? wdata : '0)) | set_i;
            end
            assign q     = st_q;
            assign rdata = st_q;
        end else begin : g_store
            logic [W-1:0] st_q;
            logic unused_st;
            assign unused_st = ^set_i;
            always_ff @(posedge clk) begin
                if (rst)     st_q <= INIT;
                else if (we) st_q <= wdata;
            end
            assign q     = st_q;
            assign rdata = (KIND == ACC_WO) ? '0 : st_q;
        end
    endgenerate

endmodule

// File: rtl/mii_phy_model.sv
module mii_phy_model
    import mii_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              link_up,
    input  mgmt_req_t         req,
    input  logic [PHY_DW-1:0] wr_data,
    output logic [PHY_DW-1:0] rd_value,
    output logic [PHY_DW-1:0] ctrl_q,
    output logic [PHY_DW-1:0] stat_q
);

    logic unused_pa;
    assign unused_pa = ^{req.phy_addr, req.rd_go};

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= CTRL_INIT;
        else if (req.wr_go && req.reg_idx == PREG_CTRL)
            ctrl_q <= strip_ctrl(wr_data);
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= merge_link(STAT_INIT, link_up);
        else     stat_q <= merge_link(stat_q, link_up);
    end

    always_comb begin
        case (req.reg_idx)
            PREG_CTRL: rd_value = ctrl_q;
            PREG_STAT: rd_value = stat_q;
            PREG_T2:   rd_value = T2_FIXED;
            default:   rd_value = '0;
        endcase
    end

endmodule

// File: rtl/mgmt_cycle_seq.sv
module mgmt_cycle_seq
    import mii_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we,
    input  logic              cmd_new_rd,
    input  logic              cmd_old_rd,
    input  logic              data_we,
    input  logic [IDX_W-1:0]  tgt_idx,
    input  logic [IDX_W-1:0]  tgt_phy,
    input  logic [PHY_DW-1:0] rd_value,
    output mgmt_req_t         req,
    output logic              busy_q,
    output logic [PHY_DW-1:0] result_q
);

    always_comb begin
        req.rd_go    = cmd_we && cmd_new_rd && !cmd_old_rd;
        req.wr_go    = data_we;
        req.reg_idx  = tgt_idx;
        req.phy_addr = tgt_phy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            result_q <= '0;
        end else begin
            busy_q <= req.rd_go || req.wr_go;
            if (req.rd_go) result_q <= rd_value;
        end
    end

endmodule

// File: rtl/mii_mgmt_front.sv
module mii_mgmt_front
    import mii_mgmt_pkg::*;
#(
    parameter int               ADDR_W   = 4,
    parameter int               DATA_W   = 32,
    parameter logic [DATA_W-1:0] ID_VALUE = 32'h0000_0A11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_waddr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [ADDR_W-1:0] host_raddr,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              link_up,
    output logic              mgmt_busy,
    output logic              op_done
);

    localparam int N_WORDS = 8;
    localparam logic [DATA_W-1:0] ZERO = '0;

    logic [N_WORDS-1:0] wsel;

    genvar gi;
    generate
        for (gi = 0; gi < N_WORDS; gi++) begin : g_wdec
            assign wsel[gi] = host_we && (host_waddr == ADDR_W'(gi));
        end
    endgenerate

    logic [DATA_W-1:0] cmd_q, cmd_rd;
    logic [DATA_W-1:0] tgt_q, tgt_rd;
    logic [PHY_DW-1:0] data_q, data_rd;
    logic [DATA_W-1:0] scr_q, scr_rd;
    logic [DATA_W-1:0] key_q, key_rd;
    logic [DATA_W-1:0] id_q, id_rd;
    logic [0:0]        done_q, done_rd;

    acc_reg #(.W(DATA_W), .KIND(ACC_RW), .INIT(ZERO)) u_cmd (
        .clk(clk), .rst(rst), .we(wsel[W_CMD]), .wdata(host_wdata),
        .set_i(ZERO), .q(cmd_q), .rdata(cmd_rd));

    acc_reg #(.W(DATA_W), .KIND(ACC_RW), .INIT(ZERO)) u_tgt (
        .clk(clk), .rst(rst), .we(wsel[W_TARGET]), .wdata(host_wdata),
        .set_i(ZERO), .q(tgt_q), .rdata(tgt_rd));

    acc_reg #(.W(PHY_DW), .KIND(ACC_RW), .INIT('0)) u_data (
        .clk(clk), .rst(rst), .we(wsel[W_DATA]), .wdata(host_wdata[PHY_DW-1:0]),
        .set_i('0), .q(data_q), .rdata(data_rd));

    acc_reg #(.W(DATA_W), .KIND(ACC_RW), .INIT(ZERO)) u_scr (
        .clk(clk), .rst(rst), .we(wsel[W_SCRATCH]), .wdata(host_wdata),
        .set_i(ZERO), .q(scr_q), .rdata(scr_rd));

    acc_reg #(.W(DATA_W), .KIND(ACC_WO), .INIT(ZERO)) u_key (
        .clk(clk), .rst(rst), .we(wsel[W_KEY]), .wdata(host_wdata),
        .set_i(ZERO), .q(key_q), .rdata(key_rd));

    acc_reg #(.W(DATA_W), .KIND(ACC_RO), .INIT(ID_VALUE)) u_id (
        .clk(clk), .rst(rst), .we(wsel[W_IDENT]), .wdata(host_wdata),
        .set_i(ZERO), .q(id_q), .rdata(id_rd));

    mgmt_req_t         req;
    logic              busy_q;
    logic [PHY_DW-1:0] result_q;
    logic [PHY_DW-1:0] phy_rd_value;
    logic [PHY_DW-1:0] phy_ctrl_w;
    logic [PHY_DW-1:0] phy_stat_w;

    mgmt_cycle_seq u_seq (
        .clk(clk), .rst(rst),
        .cmd_we(wsel[W_CMD]),
        .cmd_new_rd(host_wdata[CMD_RD_BIT]),
        .cmd_old_rd(cmd_q[CMD_RD_BIT]),
        .data_we(wsel[W_DATA]),
        .tgt_idx(tgt_q[IDX_W-1:0]),
        .tgt_phy(tgt_q[8 +: IDX_W]),
        .rd_value(phy_rd_value),
        .req(req),
        .busy_q(busy_q),
        .result_q(result_q));

    mii_phy_model u_phy (
        .clk(clk), .rst(rst), .link_up(link_up),
        .req(req), .wr_data(host_wdata[PHY_DW-1:0]),
        .rd_value(phy_rd_value), .ctrl_q(phy_ctrl_w), .stat_q(phy_stat_w));

    acc_reg #(.W(1), .KIND(ACC_W1C), .INIT(1'b0)) u_done (
        .clk(clk), .rst(rst), .we(wsel[W_IND]),
        .wdata(host_wdata[IND_DONE_BIT]), .set_i(busy_q),
        .q(done_q), .rdata(done_rd));

    logic unused_top;
    assign unused_top = ^{key_q, id_q, scr_q, data_q, done_q, key_rd};

    logic [DATA_W-1:0] ind_word;
    always_comb begin
        ind_word = '0;
        ind_word[IND_BUSY_BIT] = busy_q;
        ind_word[IND_DONE_BIT] = done_rd[0];
    end

    always_comb begin
        case (host_raddr)
            ADDR_W'(W_CMD):     host_rdata = cmd_rd;
            ADDR_W'(W_TARGET):  host_rdata = tgt_rd;
            ADDR_W'(W_DATA):    host_rdata = DATA_W'(data_rd);
            ADDR_W'(W_RESULT):  host_rdata = DATA_W'(result_q);
            ADDR_W'(W_IND):     host_rdata = ind_word;
            ADDR_W'(W_SCRATCH): host_rdata = scr_rd;
            ADDR_W'(W_KEY):     host_rdata = key_rd;
            ADDR_W'(W_IDENT):   host_rdata = id_rd;
            default:            host_rdata = '0;
        endcase
    end

    assign mgmt_busy = busy_q;
    assign op_done   = done_rd[0];

endmodule

// File: rtl/mii_mgmt_chk.sv
module mii_mgmt_chk
    import mii_mgmt_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              host_we,
    input logic [ADDR_W-1:0] host_waddr,
    input logic [DATA_W-1:0] host_wdata,
    input logic              link_up,
    input logic              mgmt_busy,
    input logic              op_done,
    input logic [PHY_DW-1:0] phy_ctrl,
    input logic [PHY_DW-1:0] phy_stat
);

    AST_BUSY_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        !host_we |=> !mgmt_busy); // R8

    AST_DATA_WRITE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_waddr == ADDR_W'(W_DATA)) |=> mgmt_busy); // R5

    AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (rst)
        mgmt_busy |=> op_done); // R9

    AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_waddr == ADDR_W'(W_IND) && host_wdata[IND_DONE_BIT] && !mgmt_busy)
        |=> !op_done); // R9

    AST_LINK_TRACK: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (phy_stat[LINK_BIT] == $past(link_up))); // R7

    AST_CTRL_STRIPPED: assert property (@(posedge clk) disable iff (rst)
        !$stable(phy_ctrl) |-> (phy_ctrl[15] == 1'b0 && phy_ctrl[8] == 1'b0)); // R6

endmodule

bind mii_mgmt_front mii_mgmt_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst(rst), .host_we(host_we), .host_waddr(host_waddr),
    .host_wdata(host_wdata), .link_up(link_up), .mgmt_busy(mgmt_busy),
    .op_done(op_done), .phy_ctrl(phy_ctrl_w), .phy_stat(phy_stat_w));

// File: tb/mii_mgmt_front_tb_top.sv
module mii_mgmt_front_tb_top;
    import mii_mgmt_pkg::*;

    localparam int AW = 4;
    localparam int DW = 32;
    localparam logic [DW-1:0] ID = 32'h0051_A5C3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_waddr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [AW-1:0] host_raddr = '0;
    logic [DW-1:0] host_rdata;
    logic          link_up = 1'b1;
    logic          mgmt_busy;
    logic          op_done;

    always #10 clk = ~clk;

    mii_mgmt_front #(.ADDR_W(AW), .DATA_W(DW), .ID_VALUE(ID)) dut_i (
        .clk(clk), .rst(rst), .host_we(host_we), .host_waddr(host_waddr),
        .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata),
        .link_up(link_up), .mgmt_busy(mgmt_busy), .op_done(op_done));

    int n_checks = 0;
    int n_errs   = 0;
    int pending  = 0;
    bit finished = 0;

    typedef struct {
        logic [AW-1:0] a;
        logic [DW-1:0] e;
        string         tag;
    } exp_t;
    exp_t sb_q[$];

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    endtask

    // scoreboard monitor: owns the read port
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                host_raddr = it.a;
                #2;
                check(it.tag, host_rdata, it.e);
                pending--;
            end
        end
    end

    task automatic expect_word(input int a, input logic [DW-1:0] e, input string tag);
        exp_t it;
        it.a = AW'(a);
        it.e = e;
        it.tag = tag;
        sb_q.push_back(it);
        pending++;
        wait (pending == 0);
    endtask

    task automatic host_write(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        host_we = 1'b1;
        host_waddr = AW'(a);
        host_wdata = d;
        @(posedge clk);
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic do_read(input logic [4:0] idx, input logic [4:0] pa);
        host_write(W_TARGET, {19'd0, pa, 3'd0, idx});
        host_write(W_CMD, 32'd0);
        host_write(W_CMD, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 busy", DW'(mgmt_busy), 0);
        check("R1 done", DW'(op_done), 0);
        for (int w = 0; w < 7; w++) expect_word(w, 32'd0, "R1 word zero");
        expect_word(W_IDENT, ID, "R1 ident");

        // R1/R3/R8 read of control register
        host_write(W_TARGET, 32'd0);
        host_write(W_CMD, 32'd1);
        check("R8 busy after read start", DW'(mgmt_busy), 1);
        host_raddr = AW'(W_RESULT);
        #1;
        check("R8 result valid with busy", host_rdata, 32'h1140);
        @(negedge clk);
        check("R8 busy one clock", DW'(mgmt_busy), 0);
        check("R9 done set", DW'(op_done), 1);
        expect_word(W_IND, 32'h2, "R9 indicator word");

        // R2 rewrite of 1 starts nothing
        host_write(W_TARGET, 32'd1);
        host_write(W_CMD, 32'd1);
        check("R2 no busy on rewrite", DW'(mgmt_busy), 0);
        expect_word(W_RESULT, 32'h1140, "R2 result unchanged");
        host_write(W_CMD, 32'hABCD_0000);
        expect_word(W_CMD, 32'hABCD_0000, "R2 full store");
        host_write(W_CMD, 32'hABCD_0001);
        check("R2 edge starts read", DW'(mgmt_busy), 1);
        expect_word(W_RESULT, 32'h780D, "R3 R7 status link up");

        // R5/R6/R4 write to control through another PHY address
        host_write(W_TARGET, 32'h0000_1F00);
        host_write(W_DATA, 32'hFFFF_FFFF);
        check("R5 write busy", DW'(mgmt_busy), 1);
        @(negedge clk);
        check("R8 write busy one clock", DW'(mgmt_busy), 0);
        expect_word(W_DATA, 32'h0000_FFFF, "R5 low half kept");
        do_read(5'd0, 5'd3);
        expect_word(W_RESULT, 32'h7EFF, "R6 R4 stripped control");

        // R6 writes to other indices ignored
        host_write(W_TARGET, 32'd1);
        host_write(W_DATA, 32'h0000_0000);
        check("R5 write cycle on idx1", DW'(mgmt_busy), 1);
        do_read(5'd1, 5'd0);
        expect_word(W_RESULT, 32'h780D, "R6 status not writable");
        host_write(W_TARGET, 32'd3);
        host_write(W_DATA, 32'h0000_1234);
        do_read(5'd0, 5'd0);
        expect_word(W_RESULT, 32'h7EFF, "R6 idx3 write ignored");

        // R3/R4 fixed and zero indices
        do_read(5'd10, 5'd5);
        expect_word(W_RESULT, 32'h1800, "R3 R4 fixed t2 status");
        do_read(5'd2, 5'd0);
        expect_word(W_RESULT, 32'h0, "R3 idx2 zero");
        do_read(5'd31, 5'd31);
        expect_word(W_RESULT, 32'h0, "R3 idx31 zero");

        // R7 link down
        link_up = 1'b0;
        repeat (2) @(negedge clk);
        do_read(5'd1, 5'd0);
        expect_word(W_RESULT, 32'h7809, "R7 status link down");

        // R11 same-cycle link change and read start
        host_write(W_CMD, 32'd0);
        @(negedge clk);
        host_we = 1'b1;
        host_waddr = AW'(W_CMD);
        host_wdata = 32'd1;
        link_up = 1'b1;
        @(posedge clk);
        @(negedge clk);
        host_we = 1'b0;
        expect_word(W_RESULT, 32'h7809, "R11 pre-edge status");
        do_read(5'd1, 5'd0);
        expect_word(W_RESULT, 32'h780D, "R11 later read sees link");

        // R9 done clear handshake
        @(negedge clk);
        host_write(W_IND, 32'h0000_0001);
        check("R9 write zero keeps done", DW'(op_done), 1);
        host_write(W_IND, 32'h0000_0002);
        check("R9 w1c clears done", DW'(op_done), 0);
        expect_word(W_IND, 32'h0, "R9 indicator cleared");

        // R10 generic access kinds
        host_write(W_SCRATCH, 32'h1234_5678);
        expect_word(W_SCRATCH, 32'h1234_5678, "R10 rw word");
        host_write(W_KEY, 32'hDEAD_BEEF);
        expect_word(W_KEY, 32'h0, "R10 wo reads zero");
        host_write(W_IDENT, 32'hFFFF_FFFF);
        expect_word(W_IDENT, ID, "R10 ro ignores write");
        host_write(9, 32'hFFFF_FFFF);
        expect_word(9, 32'h0, "R10 unknown word");
        expect_word(W_SCRATCH, 32'h1234_5678, "R10 rw untouched");
        check("R10 no busy on generic", DW'(mgmt_busy), 0);

        finished = 1;
        summary();
        $finish;
    end

endmodule